// File: doc/BRIEF.md
# Bit-Serial Shift-and-Add Multiplier

This block multiplies two unsigned W-bit operands using one single-bit full adder and a carry flip-flop, trading time for area. A pulse on `start` captures both operands. The block then runs a two-level loop. The outer loop makes one pass for each multiplier bit, from least significant to most significant. In each pass the inner loop walks the multiplicand and the running upper sum one bit per clock. When the pass ends, one boundary cycle moves the lowest finished bit of the sum into the low half of the product. The full 2W-bit result is ready after W*(W+1) clocks.

The datapath has four shift registers. A holds the multiplicand and rotates. B holds the multiplier and shifts out one bit per pass. HI holds the running upper sum. LOW collects the finished low product bits. The product port always shows `{HI, LOW}`. A controller with four named states drives the datapath through active-high strobes:
- `ST_IDLE` is the state after reset. `start` moves it to `ST_INNER` and loads the operands.
- `ST_INNER` performs one add-and-shift each clock. After W clocks it moves to `ST_STEP`.
- `ST_STEP` is the boundary cycle. It returns to `ST_INNER`, or after the W-th pass it moves to `ST_FINISH`.
- `ST_FINISH` holds `done` high. `start` reloads the operands and moves to `ST_INNER`.

Top module: `bitser_mult`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `done` is 0 and `product` is 0.
- R2: If `start` is high at a clock edge while the block is idle or finished, that edge captures `a_in` and `b_in` and clears the product. After that edge `done` is 0 and `product` is 0. Later changes on the operand inputs do not affect the result.
- R3: When `done` is high, `product` equals the unsigned product `a_in*b_in` of the captured operands, 2W bits wide.
- R4: `done` rises exactly W*(W+1) clock edges after the start edge. Each pass has two parts:
  - W add cycles, which assert shift-A, select-sum and shift-HI together.
  - Then one boundary cycle, which asserts shift-B, shift-HI, shift-LOW and carry-clear together.
- R5: While `done` is high and `start` is low, `done` stays high and `product` holds its value, whatever the operand inputs do.
- R6: A `start` pulse that arrives while a multiplication is in progress is ignored. The result and its timing belong to the original operands.
- R7: After k completed passes (k = 1..W), bits `product[W-1:W-k]` equal bits `[k-1:0]` of the final product. Bit k-1 of the final product appears at port bit W-1 at the k-th boundary.
- R8: The carry flip-flop is cleared at every boundary cycle, so no carry leaks from one pass into the next. This shows when all operand bits are ones.
- R9: The multiplicand register is back in its loaded alignment at every boundary cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (accepted when idle or finished) |
| a_in | input | W | Multiplicand |
| b_in | input | W | Multiplier |
| done | output | 1 | Result valid; held until the next accepted start |
| product | output | 2W | `{HI, LOW}`; equals a_in*b_in when done |

## Verification
A wrong counter or a wrong state transition moves the rise of `done` away from edge W*(W+1). The per-clock comparison of `done` reports this on the first clock it differs. A bad sum bit or a carry left over between passes shows up at the next boundary cycle. There the newest finished bit enters `product[W-1]`, and the progressive low-bit check catches it within W+1 clocks, long before the final result. A multiplicand that is out of alignment corrupts every later pass. The boundary-cycle assertion flags it directly, without waiting for the product to go wrong.

// File: rtl/bitser_mult_pkg.sv
package bitser_mult_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INNER  = 2'd1,
        ST_STEP   = 2'd2,
        ST_FINISH = 2'd3
    } ms_state_e;

    typedef struct packed {
        logic load;
        logic shift_a;
        logic sel_sum;
        logic shift_hi;
        logic shift_b;
        logic shift_low;
        logic clr_carry;
    } ms_strobe_t;

endpackage

// File: rtl/bitser_mult_ctrl.sv
module bitser_mult_ctrl
    import bitser_mult_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output ms_strobe_t stb,
    output logic       done
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    ms_state_e       state_q, state_d;
    logic [CW-1:0]   inner_q, outer_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: if (start) state_d = ST_INNER;
            ST_INNER:           if (inner_q == LAST) state_d = ST_STEP;
            ST_STEP:            state_d = (outer_q == LAST) ? ST_FINISH : ST_INNER;
            default:            state_d = ST_IDLE;
        endcase
    end

    // loop counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (stb.load) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (state_q == ST_INNER) begin
            inner_q <= (inner_q == LAST) ? '0 : inner_q + 1'b1;
        end else if (state_q == ST_STEP) begin
            outer_q <= outer_q + 1'b1;
        end
    end

    // strobes
    always_comb begin
        stb  = '0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   stb.load = start;
            ST_FINISH: begin
                stb.load = start;
                done     = 1'b1;
            end
            ST_INNER: begin
                stb.shift_a  = 1'b1;
                stb.sel_sum  = 1'b1;
                stb.shift_hi = 1'b1;
            end
            ST_STEP: begin
                stb.shift_b   = 1'b1;
                stb.shift_hi  = 1'b1;
                stb.shift_low = 1'b1;
                stb.clr_carry = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bitser_mult_fa.sv
module bitser_mult_fa (
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    input  logic y,
    input  logic en,
    input  logic clr,
    output logic sum,
    output logic carry_q
);
    logic cout;

    assign sum  = x ^ y ^ carry_q;
    assign cout = (x & y) | (x & carry_q) | (y & carry_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   carry_q <= 1'b0;
        else if (clr) carry_q <= 1'b0;
        else if (en)  carry_q <= cout;
    end

endmodule

// File: rtl/bitser_mult_dpath.sv
module bitser_mult_dpath
    import bitser_mult_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ms_strobe_t     stb,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    output logic [2*W-1:0] product,
    output logic [W-1:0]   a_view,
    output logic           carry
);
    logic [W-1:0] a_q, b_q, hi_q, lo_q;
    logic         pp_bit, fa_sum, hi_in;

    assign pp_bit = a_q[0] & b_q[0];

    bitser_mult_fa u_fa (
        .clk     (clk),
        .rst_n   (rst_n),
        .x       (hi_q[0]),
        .y       (pp_bit),
        .en      (stb.sel_sum),
        .clr     (stb.clr_carry | stb.load),
        .sum     (fa_sum),
        .carry_q (carry)
    );

    // sum bit during add cycles, pending carry at the boundary
    assign hi_in = stb.sel_sum ? fa_sum : carry;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            hi_q <= '0;
            lo_q <= '0;
        end else if (stb.load) begin
            a_q  <= a_in;
            b_q  <= b_in;
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (stb.shift_a)   a_q  <= {a_q[0], a_q[W-1:1]};
            if (stb.shift_b)   b_q  <= {1'b0, b_q[W-1:1]};
            if (stb.shift_hi)  hi_q <= {hi_in, hi_q[W-1:1]};
            if (stb.shift_low) lo_q <= {hi_q[0], lo_q[W-1:1]};
        end
    end

    assign product = {hi_q, lo_q};
    assign a_view  = a_q;

endmodule

// File: rtl/bitser_mult.sv
module bitser_mult
    import bitser_mult_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    output logic           done,
    output logic [2*W-1:0] product
);
    ms_strobe_t   stb;
    logic [W-1:0] a_view;
    logic         carry_s;

    bitser_mult_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .stb   (stb),
        .done  (done)
    );

    bitser_mult_dpath #(.W(W)) u_dpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .a_in    (a_in),
        .b_in    (b_in),
        .product (product),
        .a_view  (a_view),
        .carry   (carry_s)
    );

endmodule

// File: rtl/bitser_mult_chk.sv
module bitser_mult_chk
    import bitser_mult_pkg::*;
#(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done,
    input logic [2*W-1:0] product,
    input ms_strobe_t     stb,
    input logic [W-1:0]   a_in,
    input logic [W-1:0]   a_view,
    input logic           carry
);
    localparam int TOTAL = W * (W + 1);

    int           lat_q;
    int           run_q;
    logic         running_q;
    logic [W-1:0] a_snap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q     <= 0;
            run_q     <= 0;
            running_q <= 1'b0;
            a_snap    <= '0;
        end else begin
            if (stb.load) begin
                lat_q     <= 0;
                run_q     <= 0;
                running_q <= 1'b1;
                a_snap    <= a_in;
            end else begin
                if (lat_q < TOTAL + 4) lat_q <= lat_q + 1;
                if (stb.shift_b)      run_q <= 0;
                else if (stb.sel_sum) run_q <= run_q + 1;
                if (done) running_q <= 1'b0;
            end
        end
    end

    a_r4_inner_group: assert property (@(posedge clk) disable iff (!rst_n)
        stb.sel_sum |-> (stb.shift_a && stb.shift_hi && !stb.shift_b
                         && !stb.shift_low && !stb.clr_carry && !stb.load));

    a_r4_step_group: assert property (@(posedge clk) disable iff (!rst_n)
        stb.shift_low |-> (stb.shift_b && stb.shift_hi && stb.clr_carry
                           && !stb.sel_sum && !stb.shift_a && !stb.load));

    a_r4_pass_length: assert property (@(posedge clk) disable iff (!rst_n)
        stb.shift_b |-> run_q == W);

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> lat_q == TOTAL);

    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stb.load |=> (product == '0 && !done));

    a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r5_product_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(product));

    a_r6_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !done) |-> !stb.load);

    a_r8_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stb.clr_carry |=> carry == 1'b0);

    a_r9_a_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        stb.shift_b |-> a_view == a_snap);

endmodule

bind bitser_mult bitser_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .product (product),
    .stb     (stb),
    .a_in    (a_in),
    .a_view  (a_view),
    .carry   (carry_s)
);

// File: tb/bitser_mult_tb.sv
module bitser_mult_tb;
    localparam int W = 8;
    localparam int N = W * (W + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   a_in = '0;
    logic [W-1:0]   b_in = '0;
    logic           done;
    logic [2*W-1:0] product;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bitser_mult #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .a_in    (a_in),
        .b_in    (b_in),
        .done    (done),
        .product (product)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one multiplication, with an optional start pulse injected at edge inj_k
    task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                            input int inj_k, input string tag);
        logic [2*W-1:0] exp;
        longint         lo_act, lo_exp;
        int             steps;
        exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        @(negedge clk);
        a_in  = a;
        b_in  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a_in  = ~a;
        b_in  = b ^ 8'h5A;
        chk(done == 1'b0, "R2 done after start", done, 0);
        chk(product == '0, "R2 product cleared", product, 0);
        for (int k = 1; k <= N; k++) begin
            if (k == inj_k) begin
                start = 1'b1;
                a_in  = 8'd3;
                b_in  = 8'd5;
            end
            @(negedge clk);
            start = 1'b0;
            chk(done == (k == N), "R4 done timing", done, (k == N));
            steps = k / (W + 1);
            if (steps > 0) begin
                lo_act = longint'(product[W-1:0]) >> (W - steps);
                lo_exp = longint'(exp[W-1:0]) & ((64'd1 << steps) - 1);
                chk(lo_act == lo_exp, "R7 progressive low bits", lo_act, lo_exp);
            end
        end
        chk(product == exp, tag, product, exp);
        for (int h = 0; h < 4; h++) begin
            a_in = a_in + 8'd37;
            b_in = b_in ^ 8'hC3;
            @(negedge clk);
            chk(done == 1'b1, "R5 done held", done, 1);
            chk(product == exp, "R5 product held", product, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(product == '0, "R1 product in reset", product, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(product == '0, "R1 product after reset", product, 0);

        run_mult(8'd13,  8'd11,  0,  "R3 small operands");
        run_mult(8'd0,   8'd200, 0,  "R3 zero multiplicand");
        run_mult(8'd255, 8'd255, 0,  "R8 all ones carry clear");
        run_mult(8'd1,   8'd173, 0,  "R3 unit multiplicand");
        run_mult(8'h81,  8'hFF,  0,  "R9 multiplicand alignment");
        run_mult(8'd200, 8'd77,  30, "R6 start while busy ignored");
        run_mult(8'd97,  8'd0,   0,  "R3 zero multiplier");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule